// File: doc/BRIEF.md
# Return-Address Stack with Fault Reset Request

This block holds the call-return addresses of a small processor core in a last-in, first-out store. A call pushes a program-counter value. A return pops the top entry. The current top entry is always visible on `top_addr_o`. The value shown in the cycle of a pop is therefore the returned address, and an empty stack shows zero.

Two stack faults are recorded in sticky status flags:
- **Overrun:** a push arrives while every entry is in use.
- **Underrun:** a pop arrives while the stack is empty.

Each flag stays set until software strobes its own clear input or a power-on reset occurs. A configuration input selects how the block reacts to a fault:
- When the input is low, a fault only raises its flag.
- When the input is high, a fault also raises a one-cycle device-reset request. At the same time the stack pointer returns to empty, while both flags keep their values so that software can read the cause after the reset.

Top module: `ras_fault_stack`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `level_o` is 0, `top_addr_o` is 0, both flags are 0 and `reset_req_o` is 0.
- R2: A push without a pop, when `level_o` < DEPTH, stores `push_addr_i` as the new top entry. In the next cycle `level_o` is one higher and `top_addr_o` equals the pushed value.
- R3: A pop without a push, when `level_o` > 0, lowers `level_o` by one. In the cycle of the pop, `top_addr_o` carries the returned entry. An empty stack shows `top_addr_o` = 0.
- R4: A push without a pop, when `level_o` = DEPTH, sets `full_flag_o` in the next cycle and writes no entry. With the reset-enable input low, `level_o` and `top_addr_o` keep their values.
- R5: A pop when `level_o` = 0 sets `under_flag_o` in the next cycle. This holds whether or not a push arrives in the same cycle. No entry is written, `level_o` stays 0 and `top_addr_o` stays 0.
- R6: A push and a pop in the same cycle, when `level_o` > 0, replace the top entry with `push_addr_i` and leave `level_o` unchanged.
- R7: Each flag is set only by its own fault. While `rst_on_fault_i` is low, `reset_req_o` stays 0.
- R8: Each flag stays set until its own clear strobe (`clr_full_i` or `clr_under_i`) or power-on reset. A clear has no effect on the other flag. A fault in the same cycle as its clear leaves the flag set.
- R9: With `rst_on_fault_i` high, a fault sets its flag and, in the next cycle, `reset_req_o` is 1 and `level_o` is 0. The request lasts one cycle unless another fault follows.
- R10: Entries below the top are preserved, so a sequence of pops returns the pushed values in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| push_i | input | 1 | Push request (call) |
| pop_i | input | 1 | Pop request (return) |
| push_addr_i | input | AW | Address to push |
| rst_on_fault_i | input | 1 | Configuration: a fault also requests a device reset |
| clr_full_i | input | 1 | Software clear strobe for the overrun flag |
| clr_under_i | input | 1 | Software clear strobe for the underrun flag |
| top_addr_o | output | AW | Current top entry, 0 when empty |
| level_o | output | $clog2(DEPTH+1) | Number of occupied entries |
| full_flag_o | output | 1 | Sticky overrun flag |
| under_flag_o | output | 1 | Sticky underrun flag |
| reset_req_o | output | 1 | Device-reset request pulse |

## Verification
The pointer is visible on `level_o`, so a miscount shows on the edge after the push or pop that caused it.

A corrupted or misplaced entry shows on `top_addr_o` at one of two points:
- on the cycle after the write, or
- only when pops uncover it, which can be many cycles later.

For that reason the random stimulus lets the stack fill and drain repeatedly, and the bench compares the full output set on every cycle against its own model. A flag or request error appears on the cycle after the fault or clear that should have changed it.

// File: rtl/ras_pkg.sv
package ras_pkg;
   // Operation decoded from {push, pop}
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_SWAP = 2'b11
   } ras_op_e;

   // Flag indices inside the fault flag block
   localparam int FLG_FULL  = 0;
   localparam int FLG_UNDER = 1;
   localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_data
);
   logic [DEPTH*AW-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [AW-1:0] q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                          q <= '0;
         else if (wr_en && wr_idx == IW'(i))  q <= wr_data;
      end
      assign flat[i*AW +: AW] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IW'(i)) rd_data = flat[i*AW +: AW];
      end
   end
endmodule

// File: rtl/ras_ptr_ctl.sv
module ras_ptr_ctl
   import ras_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic          rst_on_fault_i,
   output logic [LW-1:0] level_o,
   output logic          wr_en_o,
   output logic [LW-1:0] wr_idx_o,
   output logic          full_evt_o,
   output logic          under_evt_o
);
   ras_op_e       op;
   logic [LW-1:0] lvl_q, lvl_d;
   logic          empty, at_cap;

   assign op     = ras_op_e'({push_i, pop_i});
   assign empty  = (lvl_q == '0);
   assign at_cap = (lvl_q == LW'(DEPTH));

   always_comb begin
      lvl_d       = lvl_q;
      wr_en_o     = 1'b0;
      full_evt_o  = 1'b0;
      under_evt_o = 1'b0;
      wr_idx_o    = (op == OP_SWAP) ? lvl_q - LW'(1) : lvl_q;
      unique case (op)
         OP_PUSH: begin
            if (at_cap) full_evt_o = 1'b1;
            else begin
               wr_en_o = 1'b1;
               lvl_d   = lvl_q + LW'(1);
            end
         end
         OP_POP: begin
            if (empty) under_evt_o = 1'b1;
            else       lvl_d = lvl_q - LW'(1);
         end
         OP_SWAP: begin
            if (empty) under_evt_o = 1'b1;
            else       wr_en_o = 1'b1;
         end
         default: ;
      endcase
      if (rst_on_fault_i && (full_evt_o || under_evt_o)) lvl_d = '0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
   end

   assign level_o = lvl_q;
endmodule

// File: rtl/ras_fault_flags.sv
module ras_fault_flags
   import ras_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic full_evt_i,
   input  logic under_evt_i,
   input  logic clr_full_i,
   input  logic clr_under_i,
   input  logic rst_on_fault_i,
   output logic full_o,
   output logic under_o,
   output logic reset_req_o
);
   logic [NUM_FLAGS-1:0] evt, clr, flg;

   assign evt[FLG_FULL]  = full_evt_i;
   assign evt[FLG_UNDER] = under_evt_i;
   assign clr[FLG_FULL]  = clr_full_i;
   assign clr[FLG_UNDER] = clr_under_i;

   // Set has priority over the software clear
   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)      flg[f] <= 1'b0;
         else if (evt[f]) flg[f] <= 1'b1;
         else if (clr[f]) flg[f] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) reset_req_o <= 1'b0;
      else        reset_req_o <= rst_on_fault_i & (|evt);
   end

   assign full_o  = flg[FLG_FULL];
   assign under_o = flg[FLG_UNDER];
endmodule

// File: rtl/ras_fault_stack.sv
module ras_fault_stack #(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   localparam int LW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] push_addr_i,
   input  logic          rst_on_fault_i,
   input  logic          clr_full_i,
   input  logic          clr_under_i,
   output logic [AW-1:0] top_addr_o,
   output logic [LW-1:0] level_o,
   output logic          full_flag_o,
   output logic          under_flag_o,
   output logic          reset_req_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ras_fault_stack: DEPTH must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("ras_fault_stack: AW must be at least 1");
   end

   logic          wr_en, full_evt, under_evt;
   logic [LW-1:0] wr_idx;
   logic [AW-1:0] rd_data;

   ras_ptr_ctl #(.DEPTH(DEPTH), .LW(LW)) u_ptr (
      .clk            (clk),
      .por_n          (por_n),
      .push_i         (push_i),
      .pop_i          (pop_i),
      .rst_on_fault_i (rst_on_fault_i),
      .level_o        (level_o),
      .wr_en_o        (wr_en),
      .wr_idx_o       (wr_idx),
      .full_evt_o     (full_evt),
      .under_evt_o    (under_evt)
   );

   ras_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wr_en),
      .wr_idx  (IW'(wr_idx)),
      .wr_data (push_addr_i),
      .rd_idx  (IW'(level_o - LW'(1))),
      .rd_data (rd_data)
   );

   ras_fault_flags u_flags (
      .clk            (clk),
      .por_n          (por_n),
      .full_evt_i     (full_evt),
      .under_evt_i    (under_evt),
      .clr_full_i     (clr_full_i),
      .clr_under_i    (clr_under_i),
      .rst_on_fault_i (rst_on_fault_i),
      .full_o         (full_flag_o),
      .under_o        (under_flag_o),
      .reset_req_o    (reset_req_o)
   );

   assign top_addr_o = (level_o == '0) ? '0 : rd_data;
endmodule

// File: rtl/ras_fault_stack_chk.sv
module ras_fault_stack_chk #(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          por_n,
   input logic          push_i,
   input logic          pop_i,
   input logic [AW-1:0] push_addr_i,
   input logic          rst_on_fault_i,
   input logic          clr_full_i,
   input logic          clr_under_i,
   input logic [AW-1:0] top_addr_o,
   input logic [LW-1:0] level_o,
   input logic          full_flag_o,
   input logic          under_flag_o,
   input logic          reset_req_o
);
   // R2
   push_grow_chk: assert property (@(posedge clk) disable iff (!por_n)
      (push_i && !pop_i && level_o < LW'(DEPTH)) |=>
         (level_o == $past(level_o) + LW'(1) && top_addr_o == $past(push_addr_i)));

   // R4
   full_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (push_i && !pop_i && level_o == LW'(DEPTH)) |=> full_flag_o);

   // R5
   under_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pop_i && level_o == '0) |=> (under_flag_o && level_o == '0));

   // R6
   swap_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (push_i && pop_i && level_o != '0) |=>
         (level_o == $past(level_o) && top_addr_o == $past(push_addr_i)));

   // R7
   no_req_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_on_fault_i |=> !reset_req_o);

   // R8
   full_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (full_flag_o && !clr_full_i) |=> full_flag_o);

   // R8
   under_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (under_flag_o && !clr_under_i) |=> under_flag_o);

   // R9
   fault_req_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rst_on_fault_i && ((push_i && !pop_i && level_o == LW'(DEPTH)) ||
                          (pop_i && level_o == '0)))
         |=> (reset_req_o && level_o == '0));

   // R3
   empty_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (level_o == '0) |-> (top_addr_o == '0));
endmodule

bind ras_fault_stack ras_fault_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk            (clk),
   .por_n          (por_n),
   .push_i         (push_i),
   .pop_i          (pop_i),
   .push_addr_i    (push_addr_i),
   .rst_on_fault_i (rst_on_fault_i),
   .clr_full_i     (clr_full_i),
   .clr_under_i    (clr_under_i),
   .top_addr_o     (top_addr_o),
   .level_o        (level_o),
   .full_flag_o    (full_flag_o),
   .under_flag_o   (under_flag_o),
   .reset_req_o    (reset_req_o)
);

// File: tb/tb_ras_fault_stack.sv
module tb_ras_fault_stack;
   localparam int CLK_P = 10;
   localparam int DEPTH = 31;
   localparam int AW    = 21;
   localparam int LW    = $clog2(DEPTH + 1);
   localparam int WD_CYC = 200000;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          push_i = 1'b0, pop_i = 1'b0;
   logic [AW-1:0] push_addr_i = '0;
   logic          rst_on_fault_i = 1'b0;
   logic          clr_full_i = 1'b0, clr_under_i = 1'b0;
   logic [AW-1:0] top_addr_o;
   logic [LW-1:0] level_o;
   logic          full_flag_o, under_flag_o, reset_req_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model
   int unsigned   m_lvl = 0;
   logic [AW-1:0] m_mem [DEPTH];
   bit            m_full = 0, m_under = 0, m_req = 0;

   always #(CLK_P/2) clk = ~clk;

   ras_fault_stack #(.DEPTH(DEPTH), .AW(AW)) dut (
      .clk, .por_n, .push_i, .pop_i, .push_addr_i, .rst_on_fault_i,
      .clr_full_i, .clr_under_i, .top_addr_o, .level_o,
      .full_flag_o, .under_flag_o, .reset_req_o
   );

   function automatic logic [AW-1:0] exp_top();
      return (m_lvl == 0) ? '0 : m_mem[m_lvl-1];
   endfunction

   function automatic string op_tag(bit ps, bit pp, bit cfg);
      bit fe = ps && !pp && m_lvl == DEPTH;
      bit ue = pp && m_lvl == 0;
      if ((fe || ue) && cfg) return "R9";
      if (fe)                return "R4";
      if (ue)                return "R5";
      if (ps && pp)          return "R6";
      if (ps)                return "R2";
      if (pp)                return "R10";
      return "R8";
   endfunction

   task automatic model_step(bit ps, bit pp, bit cfg, bit cf, bit cu, logic [AW-1:0] d);
      bit fe = ps && !pp && m_lvl == DEPTH;
      bit ue = pp && m_lvl == 0;
      if (ps && !pp && !fe) begin m_mem[m_lvl] = d; m_lvl++; end
      else if (pp && !ps && !ue) m_lvl--;
      else if (ps && pp && !ue) m_mem[m_lvl-1] = d;
      if ((fe || ue) && cfg) m_lvl = 0;
      if (fe) m_full = 1; else if (cf) m_full = 0;
      if (ue) m_under = 1; else if (cu) m_under = 0;
      m_req = cfg && (fe || ue);
   endtask

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic chk_all(string tag);
      chk(tag, "top_addr", 32'(top_addr_o), 32'(exp_top()));
      chk(tag, "level",    32'(level_o),    32'(m_lvl));
      chk(tag, "full",     32'(full_flag_o), 32'(m_full));
      chk(tag, "under",    32'(under_flag_o), 32'(m_under));
      chk(tag, "req",      32'(reset_req_o), 32'(m_req));
   endtask

   task automatic step(bit ps, bit pp, logic [AW-1:0] d, bit cfg, bit cf, bit cu, string tag);
      string t;
      @(negedge clk);
      push_i = ps; pop_i = pp; push_addr_i = d;
      rst_on_fault_i = cfg; clr_full_i = cf; clr_under_i = cu;
      t = (tag == "") ? op_tag(ps, pp, cfg) : tag;
      if (pp && !ps) chk((tag == "") ? "R3" : tag, "pop value", 32'(top_addr_o), 32'(exp_top()));
      @(posedge clk);
      model_step(ps, pp, cfg, cf, cu, d);
      #1;
      chk_all(t);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * WD_CYC);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      #(CLK_P*2 + 1);
      chk_all("R1");
      @(negedge clk); por_n = 1'b1;
      @(posedge clk); #1;
      chk_all("R1");

      // R3 empty top reads zero; R2 push, R10 LIFO order
      step(1, 0, 21'h1_2345, 0, 0, 0, "R2");
      step(1, 0, 21'h0_0ABC, 0, 0, 0, "R2");
      step(1, 0, 21'h1_FFFF, 0, 0, 0, "R2");
      step(0, 1, '0, 0, 0, 0, "R10");
      step(0, 1, '0, 0, 0, 0, "R10");
      step(0, 1, '0, 0, 0, 0, "R3");
      // R5 pop empty, R7 no request and full flag untouched
      step(0, 1, '0, 0, 0, 0, "R5");
      chk("R7", "full untouched", 32'(full_flag_o), 0);
      // R5 push+pop at empty writes nothing
      step(1, 1, 21'h0_5555, 0, 0, 0, "R5");
      // R8 clear under; clear full has no effect on under
      step(0, 0, '0, 0, 1, 0, "R8");
      chk("R8", "under kept", 32'(under_flag_o), 1);
      step(0, 0, '0, 0, 0, 1, "R8");
      // fill to capacity
      for (int i = 0; i < DEPTH; i++) step(1, 0, AW'(i * 37 + 5), 0, 0, 0, "R2");
      // R4 push at full, config clear
      step(1, 0, 21'h1_0101, 0, 0, 0, "R4");
      chk("R7", "under untouched", 32'(under_flag_o), 0);
      // R6 swap at full
      step(1, 1, 21'h0_7777, 0, 0, 0, "R6");
      // R8 set beats clear in same cycle
      step(1, 0, 21'h0_0001, 0, 1, 0, "R8");
      // R9 fault with reset enabled
      step(1, 0, 21'h0_0002, 1, 0, 0, "R9");
      step(0, 0, '0, 0, 0, 0, "R9");
      step(0, 1, '0, 1, 0, 1, "R9");
      step(0, 0, '0, 1, 1, 1, "R8");

      // constrained random
      for (int it = 0; it < 4000; it++) begin
         int pct;
         bit ps, pp;
         case ((it / 400) % 4)
            0: pct = 70;
            1: pct = 30;
            2: pct = 50;
            default: pct = 90;
         endcase
         ps = ($urandom % 100) < pct;
         pp = ($urandom % 100) < (100 - pct);
         if ($urandom % 10 == 0) begin ps = 1; pp = 1; end
         step(ps, pp, AW'($urandom), ($urandom % 16) == 0,
              ($urandom % 8) == 0, ($urandom % 8) == 0, "");
      end
      finish_run();
   end
endmodule